// File: doc/BRIEF.md
# AC-Coupled Link Pulse Test Driver

This block sequences the output drivers of a boundary-scan chain when the pins under test are joined to their receivers through series capacitors. A steady level never crosses such a link, so a plain static drive proves nothing. The driver turns each latched boundary value into timed edges instead. It sees the TAP controller only through three state indications: Test-Logic-Reset, Update (DR or IR), and Run-Test/Idle. It runs on the falling edge of the test clock, and a synchronous active-high reset also clears it.

Each pin has a data cell and an enable cell. Both are captured in the Update state. The data bit goes straight onto the pin. When the controller then sits in Run-Test/Idle, the pin first drives the inverted bit. In pulse mode it holds that inverted level. In train mode it keeps toggling on every falling edge. When the controller moves on, the pin returns to the true bit. After that the pin makes no further edges until the next update. In static mode the pin just holds the captured bit, as ordinary external test would.

Top module: `acpt_driver`

## Requirements
- R1: On a falling edge of `tck_i` with `rst_i` or `tlr_i` high, every `pin_o` and `oe_o` bit goes to 0, and any sequence in progress is abandoned.
- R2: On a falling edge with `upd_i` high, `pin_o` takes `bsr_data_i` and `oe_o` takes `bsr_ctl_i`.
- R3: With `mode_i` = 2'b01 (pulse) or 2'b10 (train), the first falling edge seen in Run-Test/Idle after an update drives the inverted captured bit on each pin.
- R4: In pulse mode, later falling edges in the same Run-Test/Idle stay make no change to `pin_o`.
- R5: In train mode, every later falling edge in the same Run-Test/Idle stay inverts `pin_o`.
- R6: On any falling edge where none of `tlr_i`, `upd_i` and `rti_i` is high, `pin_o` equals the captured bit.
- R7: Once a Run-Test/Idle stay has ended, a later stay in Run-Test/Idle without a new update keeps `pin_o` at the captured bit.
- R8: With `mode_i` = 2'b00 or 2'b11 (static), `pin_o` equals the captured bit on every edge, including edges in Run-Test/Idle.
- R9: If the controller leaves Update without spending a falling edge in Run-Test/Idle, no inverted level appears. The sequence stays armed for the next Run-Test/Idle entry.
- R10: `oe_o` changes only on reset, Test-Logic-Reset or update edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock; all state changes on its falling edge |
| rst_i | input | 1 | Synchronous active-high reset |
| tlr_i | input | 1 | Controller is in Test-Logic-Reset |
| upd_i | input | 1 | Controller is in Update-DR or Update-IR |
| rti_i | input | 1 | Controller is in Run-Test/Idle |
| mode_i | input | 2 | 00/11 static, 01 single pulse, 10 train |
| bsr_data_i | input | NPINS | Boundary data cell per pin |
| bsr_ctl_i | input | NPINS | Boundary enable cell per pin |
| pin_o | output | NPINS | Driven level per pin |
| oe_o | output | NPINS | Output enable per pin |

## Verification
The assertions assume that at most one of the three state indications is high on any falling edge, since a real controller occupies one state at a time. They also assume the mode is held steady while the controller stays in Run-Test/Idle. The stimulus meets both. It drives a single encoded controller state and decodes it into the three lines, and it changes the mode only in the cycle that carries an update. Random rounds vary the dwell in Run-Test/Idle from zero edges upward, so that the skip, the long-pulse and the long-train cases all occur.

// File: rtl/acpt_pkg.sv
package acpt_pkg;

    typedef enum logic [1:0] {
        MODE_STATIC = 2'b00,
        MODE_PULSE  = 2'b01,
        MODE_TRAIN  = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        PH_OFF    = 2'b00,
        PH_ARMED  = 2'b01,
        PH_ACTIVE = 2'b10,
        PH_DONE   = 2'b11
    } phase_e;

    typedef enum logic [2:0] {
        ACT_CLEAR  = 3'd0,
        ACT_LOAD   = 3'd1,
        ACT_INVERT = 3'd2,
        ACT_TOGGLE = 3'd3,
        ACT_TRUE   = 3'd4,
        ACT_HOLD   = 3'd5
    } act_e;

    // Level a pin drives after an edge, given the action, its present level
    // and its captured bit (load and clear are handled by the cell itself).
    function automatic logic next_level(act_e act, logic cur, logic data);
        logic lvl;
        case (act)
            ACT_INVERT: lvl = ~data;
            ACT_TOGGLE: lvl = ~cur;
            ACT_HOLD:   lvl = cur;
            default:    lvl = data;
        endcase
        return lvl;
    endfunction

    function automatic logic is_dynamic(logic [1:0] mode);
        return (mode == MODE_PULSE) || (mode == MODE_TRAIN);
    endfunction

endpackage

// File: rtl/acpt_sequencer.sv
module acpt_sequencer
    import acpt_pkg::*;
(
    input  logic       tck_i,
    input  logic       rst_i,
    input  logic       tlr_i,
    input  logic       upd_i,
    input  logic       rti_i,
    input  logic [1:0] mode_i,
    output act_e       act_o
);

    phase_e phase_q;
    phase_e phase_d;
    act_e   act_d;

    always_comb begin
        phase_d = phase_q;
        act_d   = ACT_TRUE;
        if (rst_i || tlr_i) begin
            phase_d = PH_OFF;
            act_d   = ACT_CLEAR;
        end else if (upd_i) begin
            phase_d = PH_ARMED;
            act_d   = ACT_LOAD;
        end else if (rti_i) begin
            if (is_dynamic(mode_i)) begin
                case (phase_q)
                    PH_ARMED: begin
                        phase_d = PH_ACTIVE;
                        act_d   = ACT_INVERT;
                    end
                    PH_ACTIVE: begin
                        act_d = (mode_i == MODE_TRAIN) ? ACT_TOGGLE : ACT_HOLD;
                    end
                    default: act_d = ACT_TRUE;
                endcase
            end
        end else begin
            if (phase_q == PH_ACTIVE) begin
                phase_d = PH_DONE;
            end
        end
    end

    always_ff @(negedge tck_i) begin
        phase_q <= phase_d;
    end

    assign act_o = act_d;

endmodule

// File: rtl/acpt_pin_cell.sv
module acpt_pin_cell
    import acpt_pkg::*;
(
    input  logic tck_i,
    input  act_e act_i,
    input  logic data_i,
    input  logic ctl_i,
    output logic cap_o,
    output logic pin_o,
    output logic oe_o
);

    logic data_q;
    logic ctl_q;
    logic out_q;

    always_ff @(negedge tck_i) begin
        case (act_i)
            ACT_CLEAR: begin
                data_q <= 1'b0;
                ctl_q  <= 1'b0;
                out_q  <= 1'b0;
            end
            ACT_LOAD: begin
                data_q <= data_i;
                ctl_q  <= ctl_i;
                out_q  <= data_i;
            end
            default: begin
                out_q <= next_level(act_i, out_q, data_q);
            end
        endcase
    end

    assign cap_o = data_q;
    assign pin_o = out_q;
    assign oe_o  = ctl_q;

endmodule

// File: rtl/acpt_driver.sv
module acpt_driver
    import acpt_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic             tck_i,
    input  logic             rst_i,
    input  logic             tlr_i,
    input  logic             upd_i,
    input  logic             rti_i,
    input  logic [1:0]       mode_i,
    input  logic [NPINS-1:0] bsr_data_i,
    input  logic [NPINS-1:0] bsr_ctl_i,
    output logic [NPINS-1:0] pin_o,
    output logic [NPINS-1:0] oe_o
);

    act_e             act_w;
    logic [NPINS-1:0] cap_w;

    acpt_sequencer seq_i (
        .tck_i  (tck_i),
        .rst_i  (rst_i),
        .tlr_i  (tlr_i),
        .upd_i  (upd_i),
        .rti_i  (rti_i),
        .mode_i (mode_i),
        .act_o  (act_w)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        acpt_pin_cell cell_i (
            .tck_i  (tck_i),
            .act_i  (act_w),
            .data_i (bsr_data_i[g]),
            .ctl_i  (bsr_ctl_i[g]),
            .cap_o  (cap_w[g]),
            .pin_o  (pin_o[g]),
            .oe_o   (oe_o[g])
        );
    end

endmodule

// File: rtl/acpt_driver_chk.sv
module acpt_driver_chk
    import acpt_pkg::*;
#(
    parameter int NPINS = 4
) (
    input logic             tck_i,
    input logic             rst_i,
    input logic             tlr_i,
    input logic             upd_i,
    input logic             rti_i,
    input logic [1:0]       mode_i,
    input logic [NPINS-1:0] bsr_data_i,
    input logic [NPINS-1:0] bsr_ctl_i,
    input logic [NPINS-1:0] pin_o,
    input logic [NPINS-1:0] oe_o,
    input logic [NPINS-1:0] cap_i
);

    p_clear_r1: assert property (@(negedge tck_i) disable iff (rst_i)
        tlr_i |=> (pin_o == '0) && (oe_o == '0));

    p_load_r2: assert property (@(negedge tck_i) disable iff (rst_i)
        (upd_i && !tlr_i) |=> (pin_o == $past(bsr_data_i)) && (oe_o == $past(bsr_ctl_i)));

    p_pulse_hold_r4: assert property (@(negedge tck_i) disable iff (rst_i)
        (rti_i && $past(rti_i) && mode_i == MODE_PULSE && $past(mode_i) == MODE_PULSE)
        |=> pin_o == $past(pin_o));

    // covers R9 as well: leaving Update for a non-idle state keeps the true bit
    p_true_level_r6: assert property (@(negedge tck_i) disable iff (rst_i)
        (!tlr_i && !upd_i && !rti_i) |=> pin_o == cap_i);

    p_static_r8: assert property (@(negedge tck_i) disable iff (rst_i)
        (!tlr_i && !upd_i && !is_dynamic(mode_i)) |=> pin_o == cap_i);

    p_oe_steady_r10: assert property (@(negedge tck_i) disable iff (rst_i)
        (!tlr_i && !upd_i) |=> $stable(oe_o));

endmodule

bind acpt_driver acpt_driver_chk #(.NPINS(NPINS)) chk_i (
    .tck_i      (tck_i),
    .rst_i      (rst_i),
    .tlr_i      (tlr_i),
    .upd_i      (upd_i),
    .rti_i      (rti_i),
    .mode_i     (mode_i),
    .bsr_data_i (bsr_data_i),
    .bsr_ctl_i  (bsr_ctl_i),
    .pin_o      (pin_o),
    .oe_o       (oe_o),
    .cap_i      (cap_w)
);

// File: tb/acpt_driver_tb_top.sv
module acpt_driver_tb_top;

    localparam int NPINS = 4;
    localparam int ST_OTHER = 0, ST_TLR = 1, ST_UPD = 2, ST_RTI = 3;

    logic             tck = 1'b1;
    logic             rst, tlr, upd, rti;
    logic [1:0]       mode;
    logic [NPINS-1:0] bsr_data, bsr_ctl;
    logic [NPINS-1:0] pin, oe;

    always #4 tck = ~tck;

    acpt_driver #(.NPINS(NPINS)) dut_i (
        .tck_i(tck), .rst_i(rst), .tlr_i(tlr), .upd_i(upd), .rti_i(rti),
        .mode_i(mode), .bsr_data_i(bsr_data), .bsr_ctl_i(bsr_ctl),
        .pin_o(pin), .oe_o(oe)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string req_tag  = "R1";

    // behavioural reference
    logic [NPINS-1:0] m_data = '0, m_ctl = '0, m_out = '0;
    bit               m_armed = 0;
    int               m_run = 0;

    function automatic void model_edge(int st, bit r, logic [1:0] md,
                                       logic [NPINS-1:0] d, logic [NPINS-1:0] c);
        bit dyn = (md == 2'b01) || (md == 2'b10);
        if (r || st == ST_TLR) begin
            m_data = '0; m_ctl = '0; m_out = '0; m_armed = 0; m_run = 0;
        end else if (st == ST_UPD) begin
            m_data = d; m_ctl = c; m_out = d; m_armed = 1; m_run = 0;
        end else if (st == ST_RTI) begin
            if (dyn && m_armed) begin
                m_run++;
                if (md == 2'b10 && (m_run % 2 == 0)) m_out = m_data;
                else m_out = ~m_data;
            end else begin
                m_out = m_data;
            end
        end else begin
            if (m_run > 0) begin
                m_armed = 0;
                m_run = 0;
            end
            m_out = m_data;
        end
    endfunction

    task automatic compare();
        n_checks++;
        if (pin !== m_out) begin
            n_fail++;
            $display("FAIL %s pin_o actual=%b expected=%b t=%0t", req_tag, pin, m_out, $time);
        end
        n_checks++;
        if (oe !== m_ctl) begin
            n_fail++;
            $display("FAIL %s oe_o actual=%b expected=%b t=%0t", req_tag, oe, m_ctl, $time);
        end
    endtask

    task automatic apply(int st, bit r, logic [1:0] md,
                         logic [NPINS-1:0] d, logic [NPINS-1:0] c);
        rst = r;
        tlr = (st == ST_TLR);
        upd = (st == ST_UPD);
        rti = (st == ST_RTI);
        mode = md; bsr_data = d; bsr_ctl = c;
        model_edge(st, r, md, d, c);
    endtask

    // compare result of previous falling edge, then drive the next state
    task automatic step(int st, logic [1:0] md = mode,
                        logic [NPINS-1:0] d = bsr_data, logic [NPINS-1:0] c = bsr_ctl);
        @(posedge tck);
        compare();
        apply(st, 1'b0, md, d, c);
    endtask

    task automatic run_n(int st, int n);
        for (int i = 0; i < n; i++) step(st);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        apply(ST_OTHER, 1'b1, 2'b01, 4'b1111, 4'b1111);
        // R1: reset state
        req_tag = "R1";
        for (int i = 0; i < 3; i++) begin
            @(posedge tck); compare(); apply(ST_OTHER, 1'b1, 2'b01, 4'b1111, 4'b1111);
        end
        // R2: update captures data and enable
        req_tag = "R2";
        step(ST_UPD, 2'b01, 4'b1010, 4'b1100);
        run_n(ST_OTHER, 1);
        // R3 and R4: single pulse held across a long idle
        req_tag = "R3";
        step(ST_RTI);
        req_tag = "R4";
        run_n(ST_RTI, 6);
        // R6: leaving idle returns the true bit
        req_tag = "R6";
        run_n(ST_OTHER, 2);
        // R7: second idle stay without update makes no edge
        req_tag = "R7";
        run_n(ST_RTI, 3);
        run_n(ST_OTHER, 1);
        // R5: train toggles while idle
        req_tag = "R5";
        step(ST_UPD, 2'b10, 4'b0110, 4'b1111);
        run_n(ST_RTI, 7);
        run_n(ST_OTHER, 1);
        req_tag = "R7";
        run_n(ST_RTI, 4);
        run_n(ST_OTHER, 1);
        // R8: static mode ignores idle
        req_tag = "R8";
        step(ST_UPD, 2'b00, 4'b1001, 4'b0101);
        run_n(ST_RTI, 4);
        step(ST_UPD, 2'b11, 4'b0111, 4'b0011);
        run_n(ST_RTI, 3);
        run_n(ST_OTHER, 1);
        // R9: zero-length idle stay, later entry still pulses
        req_tag = "R9";
        step(ST_UPD, 2'b01, 4'b1100, 4'b1010);
        run_n(ST_OTHER, 3);
        run_n(ST_RTI, 2);
        run_n(ST_OTHER, 1);
        // R1: Test-Logic-Reset abandons a train mid-stay
        req_tag = "R1";
        step(ST_UPD, 2'b10, 4'b0011, 4'b1111);
        run_n(ST_RTI, 3);
        step(ST_TLR);
        run_n(ST_RTI, 2);
        // R10 and all others: random rounds
        req_tag = "R10";
        for (int k = 0; k < 60; k++) begin
            step(ST_UPD, 2'($urandom_range(0, 3)), 4'($urandom), 4'($urandom));
            run_n(ST_OTHER, $urandom_range(0, 2));
            run_n(ST_RTI, $urandom_range(0, 7));
            run_n(ST_OTHER, $urandom_range(1, 3));
            if ($urandom_range(0, 7) == 0) step(ST_TLR);
        end
        @(posedge tck);
        compare();
        finish_run();
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule